// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a compact processor that finishes every instruction in one clock cycle. It supports a small load/store instruction subset: register-to-register arithmetic and logic, word load, word store, branch on equal, and an absolute jump. The core contains the program counter and its next-address selection, a 32-entry register file, the immediate sign extender, the ALU and the main decoder. Multiplexers driven by the decoder choose the register write destination, the second ALU operand and the write-back value.

Instruction memory and data memory are small word-addressed arrays inside the core. The testbench fills them before it releases reset. The only way to see results from outside is a debug port that reads any register combinationally. Instructions are 32 bits wide. The opcode is in bits 31:26, the first source register in 25:21, the second source/target register in 20:16, the R-type destination in 15:11, the shift amount field in 10:6, the function code in 5:0, and the 16-bit immediate in 15:0.

Top module: `sc_core`

## Requirements
- R1: Pulling rst_ni low clears the program counter to 0 at once. While reset is held, and until its release has passed through two synchronizing flops, neither the register file nor data memory is written. Fetching then starts at byte address 0.
- R2: Every instruction other than a taken branch or a jump sets the program counter to its current value plus 4.
- R3: Opcode 0x00 with a zero shift field selects an ALU operation on registers rs and rt, and the result goes to rd (bits 15:11). The function codes are add 0x20, subtract 0x22, AND 0x24, OR 0x25, NOR 0x27, and set-on-less-than 0x2A, which compares signed and writes 1 or 0.
- R4: Opcode 0x00 with any other function code, or with a nonzero shift field, writes neither a register nor memory.
- R5: Load word (opcode 0x23) writes to rt (bits 20:16) the data word at byte address rs plus the sign-extended immediate. Address bits 1:0 are ignored, and the word index wraps modulo DMEM_WORDS.
- R6: Store word (opcode 0x2B) writes register rt to data memory at the same kind of address and leaves the register file unchanged.
- R7: Branch on equal (opcode 0x04) subtracts rt from rs. If the result is zero, the next PC is PC+4 plus the sign-extended immediate times 4; otherwise it is PC+4.
- R8: Jump (opcode 0x02) loads the PC with PC bits 31:28, then instruction bits 25:0, then two zero bits.
- R9: Any opcode not listed above writes neither a register nor memory and advances the PC by 4.
- R10: Register 0 always reads as zero through every read port, and writes to it are discarded.
- R11: dbg_data_o shows, in the same cycle, the register selected by dbg_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously |
| dbg_addr_i | input | 5 | Register number for the debug read |
| dbg_data_o | output | 32 | Contents of the selected register |

## Verification
The bench builds the core with IMEM_WORDS = 32 and DMEM_WORDS = 8. A whole program then fits in a few dozen words, and the data memory index is only three bits wide, so the byte-address-to-word-index slicing and the negative-offset address arithmetic land on known words. The program executes a not-taken and a taken branch, forward jumps over instructions that would corrupt a register, writes aimed at register 0, and undefined opcodes and function codes. A second run, started by a mid-program reset with changed data, reverses the branch outcome and shows that execution restarts at address 0.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int unsigned XLEN    = 32;
  localparam int unsigned NREG    = 32;
  localparam int unsigned RIDX_W  = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;    // write destination: 1 = rd field, 0 = rt field
    logic    b_imm;     // second ALU operand: 1 = sign-extended immediate
    logic    wb_mem;    // write-back source: 1 = data memory
    logic    reg_we;
    logic    mem_we;
    logic    is_beq;
    logic    is_jump;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  input  logic [4:0] shamt_i,
  output ctrl_t      ctrl_o
);

  logic    fn_ok;
  alu_op_e fn_op;

  always_comb begin
    fn_ok = (shamt_i == 5'd0);
    fn_op = ALU_ADD;
    unique case (funct_i)
      FN_ADD:  fn_op = ALU_ADD;
      FN_SUB:  fn_op = ALU_SUB;
      FN_AND:  fn_op = ALU_AND;
      FN_OR:   fn_op = ALU_OR;
      FN_NOR:  fn_op = ALU_NOR;
      FN_SLT:  fn_op = ALU_SLT;
      default: fn_ok = 1'b0;
    endcase
  end

  always_comb begin
    ctrl_o = '{dst_rd: 1'b0, b_imm: 1'b0, wb_mem: 1'b0, reg_we: 1'b0,
               mem_we: 1'b0, is_beq: 1'b0, is_jump: 1'b0, alu_op: ALU_ADD};
    unique case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.reg_we = fn_ok;
        ctrl_o.alu_op = fn_op;
      end
      OP_LOAD: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.wb_mem = 1'b1;
        ctrl_o.reg_we = 1'b1;
      end
      OP_STORE: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.mem_we = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.is_beq = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      OP_JUMP: ctrl_o.is_jump = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);

  logic [W-1:0] diff;
  assign diff = a_i - b_i;

  always_comb begin
    unique case (op_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = diff;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      ALU_NOR: y_o = ~(a_i | b_i);
      default: y_o = '0;
    endcase
  end

  assign zero_o = (y_o == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned NREG  = 32,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  input  logic [AW-1:0] ra_a_i,
  output logic [W-1:0]  rd_a_o,
  input  logic [AW-1:0] ra_b_i,
  output logic [W-1:0]  rd_b_o,
  input  logic [AW-1:0] ra_d_i,
  output logic [W-1:0]  rd_d_o
);

  logic [W-1:0] regs_q [1:NREG-1];

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    logic en;
    assign en = we_i && (wa_i == AW'(g));
    always_ff @(posedge clk_i) begin
      if (en) regs_q[g] <= wd_i;
    end
  end

  assign rd_a_o = (ra_a_i == '0) ? '0 : regs_q[ra_a_i];
  assign rd_b_o = (ra_b_i == '0) ? '0 : regs_q[ra_b_i];
  assign rd_d_o = (ra_d_i == '0) ? '0 : regs_q[ra_d_i];

endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 256,
  parameter int unsigned DMEM_WORDS = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RIDX_W-1:0] dbg_addr_i,
  output logic [XLEN-1:0]   dbg_data_o
);

  localparam int unsigned IAW = (IMEM_WORDS > 1) ? $clog2(IMEM_WORDS) : 1;
  localparam int unsigned DAW = (DMEM_WORDS > 1) ? $clog2(DMEM_WORDS) : 1;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n_core;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_core = rst_sync_q[1];

  // fetch
  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_target, j_target;
  logic [XLEN-1:0] instr;

  sc_mem #(.DEPTH(IMEM_WORDS), .W(XLEN)) u_imem (
    .clk_i   (clk_i),
    .we_i    (1'b0),
    .waddr_i ('0),
    .wdata_i ('0),
    .raddr_i (pc_q[IAW+1:2]),
    .rdata_o (instr)
  );

  // decode
  logic [5:0]        opcode, funct;
  logic [4:0]        shamt;
  logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
  logic [XLEN-1:0]   imm_sx;
  ctrl_t             ctrl;

  assign opcode = instr[31:26];
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign shamt  = instr[10:6];
  assign funct  = instr[5:0];
  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_ctrl u_ctrl (
    .opcode_i (opcode),
    .funct_i  (funct),
    .shamt_i  (shamt),
    .ctrl_o   (ctrl)
  );

  // register file
  logic [XLEN-1:0] rs_val, rt_val, wb_data;
  logic            rf_we;

  assign wr_idx = ctrl.dst_rd ? rd_idx : rt_idx;
  assign rf_we  = ctrl.reg_we && rst_n_core;

  sc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk_i  (clk_i),
    .we_i   (rf_we),
    .wa_i   (wr_idx),
    .wd_i   (wb_data),
    .ra_a_i (rs_idx),
    .rd_a_o (rs_val),
    .ra_b_i (rt_idx),
    .rd_b_o (rt_val),
    .ra_d_i (dbg_addr_i),
    .rd_d_o (dbg_data_o)
  );

  // execute
  logic [XLEN-1:0] alu_b, alu_y;
  logic            alu_zero;

  assign alu_b = ctrl.b_imm ? imm_sx : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .op_i   (ctrl.alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  // data memory
  logic [XLEN-1:0] dm_rdata;
  logic            dm_we;

  assign dm_we = ctrl.mem_we && rst_n_core;

  sc_mem #(.DEPTH(DMEM_WORDS), .W(XLEN)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (dm_we),
    .waddr_i (alu_y[DAW+1:2]),
    .wdata_i (rt_val),
    .raddr_i (alu_y[DAW+1:2]),
    .rdata_o (dm_rdata)
  );

  assign wb_data = ctrl.wb_mem ? dm_rdata : alu_y;

  // next PC
  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign j_target  = {pc_q[XLEN-1:XLEN-4], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.is_jump)                 pc_d = j_target;
    else if (ctrl.is_beq && alu_zero) pc_d = br_target;
    else                              pc_d = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_n_core) begin
    if (!rst_n_core) pc_q <= '0;
    else             pc_q <= pc_d;
  end

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk_i,
  input logic        rst_n_i,
  input logic [31:0] pc_i,
  input logic [31:0] instr_i,
  input logic [31:0] rs_val_i,
  input logic [31:0] rt_val_i,
  input logic        rf_we_i,
  input logic        dm_we_i,
  input logic [4:0]  dbg_addr_i,
  input logic [31:0] dbg_data_i
);

  logic [5:0]  op;
  logic        op_known, fn_known;
  logic [31:0] beq_next, jmp_next;

  assign op       = instr_i[31:26];
  assign op_known = (op == 6'h00) || (op == 6'h23) || (op == 6'h2B) ||
                    (op == 6'h04) || (op == 6'h02);
  assign fn_known = (instr_i[10:6] == 5'd0) &&
                    ((instr_i[5:0] == 6'h20) || (instr_i[5:0] == 6'h22) ||
                     (instr_i[5:0] == 6'h24) || (instr_i[5:0] == 6'h25) ||
                     (instr_i[5:0] == 6'h27) || (instr_i[5:0] == 6'h2A));
  assign beq_next = (rs_val_i == rt_val_i)
                  ? pc_i + 32'd4 + {{14{instr_i[15]}}, instr_i[15:0], 2'b00}
                  : pc_i + 32'd4;
  assign jmp_next = {pc_i[31:28], instr_i[25:0], 2'b00};

  // R2
  pc_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (op != 6'h04 && op != 6'h02) |=> pc_i == $past(pc_i) + 32'd4);

  // R7
  beq_next_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (op == 6'h04) |=> pc_i == $past(beq_next));

  // R8
  jump_next_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (op == 6'h02) |=> pc_i == $past(jmp_next));

  // R6
  store_no_rf_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (op == 6'h2B) |-> (dm_we_i && !rf_we_i));

  // R9
  unknown_op_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !op_known |-> (!rf_we_i && !dm_we_i));

  // R4
  unknown_fn_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (op == 6'h00 && !fn_known) |-> (!rf_we_i && !dm_we_i));

  // R10
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (dbg_addr_i == 5'd0) |-> (dbg_data_i == 32'd0));

  // R2
  pc_align_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    pc_i[1:0] == 2'b00);

endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_n_core),
  .pc_i       (pc_q),
  .instr_i    (instr),
  .rs_val_i   (rs_val),
  .rt_val_i   (rt_val),
  .rf_we_i    (rf_we),
  .dm_we_i    (dm_we),
  .dbg_addr_i (dbg_addr_i),
  .dbg_data_i (dbg_data_o)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;

  localparam int IMW = 32;
  localparam int DMW = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  dbg_addr = 5'd0;
  logic [31:0] dbg_data;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;  // 4 ns period

  sc_core #(.IMEM_WORDS(IMW), .DMEM_WORDS(DMW)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .dbg_addr_i (dbg_addr),
    .dbg_data_o (dbg_data)
  );

  function automatic logic [31:0] rt_(input int rs, rt, rd, sh, fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] it_(input int op, rs, rt, input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] jt_(input int word);
    return {6'h02, 26'(word)};
  endfunction

  localparam logic [31:0] PROG [IMW] = '{
    it_(8'h23, 0, 1, 16'd0),        // 0  load r1 = 5            (R5)
    it_(8'h23, 0, 2, 16'd4),        // 1  load r2 = 3
    it_(8'h23, 0, 3, 16'd8),        // 2  load r3 = -16
    rt_(1, 2, 4, 0, 8'h20),         // 3  r4 = r1 + r2           (R3)
    rt_(1, 2, 5, 0, 8'h22),         // 4  r5 = r1 - r2
    rt_(1, 2, 6, 0, 8'h24),         // 5  r6 = r1 & r2
    rt_(1, 2, 7, 0, 8'h25),         // 6  r7 = r1 | r2
    rt_(3, 1, 8, 0, 8'h2A),         // 7  r8 = (-16 < 5)
    rt_(1, 3, 9, 0, 8'h2A),         // 8  r9 = (5 < -16)
    rt_(1, 2, 10, 0, 8'h27),        // 9  r10 = ~(r1 | r2)
    it_(8'h2B, 0, 4, 16'd12),       // 10 store r4 at word 3     (R6)
    it_(8'h23, 0, 11, 16'd12),      // 11 load r11 from word 3
    rt_(1, 2, 0, 0, 8'h20),         // 12 write aimed at r0      (R10)
    it_(8'h04, 1, 2, 16'd5),        // 13 beq not taken          (R7)
    it_(8'h23, 4, 12, 16'hFFFC),    // 14 load r12 from r4 - 4
    it_(8'h04, 2, 12, 16'd2),       // 15 beq taken when r2==r12
    rt_(1, 1, 4, 0, 8'h20),         // 16 r4 = r1 + r1 (branch skips)
    rt_(1, 1, 4, 0, 8'h20),         // 17
    jt_(21),                        // 18 jump                   (R8)
    rt_(1, 2, 4, 0, 8'h22),         // 19 skipped by jump
    rt_(1, 2, 4, 0, 8'h22),         // 20
    it_(8'h23, 0, 15, 16'd0),       // 21 load r15
    it_(8'h3F, 1, 15, 16'd0),       // 22 unknown opcode         (R9)
    rt_(1, 2, 15, 1, 8'h20),        // 23 nonzero shift field    (R4)
    rt_(1, 2, 15, 0, 8'h03),        // 24 unknown function code
    rt_(0, 2, 13, 0, 8'h20),        // 25 r13 = r0 + r2
    jt_(26),                        // 26 halt loop
    32'd0, 32'd0, 32'd0, 32'd0, 32'd0
  };

  // {requirement number, register, expected value}
  localparam logic [44:0] EXP1 [15] = '{
    {8'd10, 5'd0,  32'h0000_0000},  // R10
    {8'd5,  5'd1,  32'h0000_0005},  // R5
    {8'd5,  5'd2,  32'h0000_0003},
    {8'd5,  5'd3,  32'hFFFF_FFF0},
    {8'd8,  5'd4,  32'h0000_0008},  // R8 and R7 skipped writes
    {8'd3,  5'd5,  32'h0000_0002},  // R3
    {8'd3,  5'd6,  32'h0000_0001},
    {8'd3,  5'd7,  32'h0000_0007},
    {8'd3,  5'd8,  32'h0000_0001},
    {8'd3,  5'd9,  32'h0000_0000},
    {8'd3,  5'd10, 32'hFFFF_FFF8},
    {8'd6,  5'd11, 32'h0000_0008},  // R6
    {8'd7,  5'd12, 32'h0000_0003},  // R7
    {8'd10, 5'd13, 32'h0000_0003},
    {8'd9,  5'd15, 32'h0000_0005}   // R9 and R4
  };

  task automatic check(input string req, input int rg, input logic [31:0] exp);
    dbg_addr = 5'(rg);
    #1;
    n_chk++;
    if (dbg_data !== exp) begin
      n_fail++;
      $display("FAIL %s r%0d actual=%h expected=%h", req, rg, dbg_data, exp);
    end
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < IMW; i++) u_dut.u_imem.mem_q[i] = PROG[i];
    for (int i = 0; i < DMW; i++) u_dut.u_dmem.mem_q[i] = 32'd0;
    u_dut.u_dmem.mem_q[0] = 32'd5;
    u_dut.u_dmem.mem_q[1] = 32'd3;
    u_dut.u_dmem.mem_q[2] = 32'hFFFF_FFF0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 0, 32'd0);  // reset state: r0 reads zero, R11 port live
    rst_ni = 1'b1;
    repeat (80) @(negedge clk);

    for (int i = 0; i < 15; i++)
      check($sformatf("R%0d", EXP1[i][44:37]), int'(EXP1[i][36:32]), EXP1[i][31:0]);

    // R1: reset mid-program; no writes while held
    @(negedge clk);
    rst_ni = 1'b0;
    u_dut.u_dmem.mem_q[0] = 32'd9;
    repeat (10) @(negedge clk);
    check("R1", 1, 32'd5);
    check("R1", 11, 32'd8);
    rst_ni = 1'b1;
    repeat (80) @(negedge clk);

    // rerun from address 0 with r1 = 9: branch at 15 now falls through
    check("R1", 1, 32'd9);
    check("R3", 5, 32'd6);
    check("R6", 11, 32'd12);
    check("R5", 12, 32'hFFFF_FFF0);  // r4 - 4 = 8 -> word 2
    check("R7", 4, 32'd18);          // 16/17 executed after not-taken beq
    check("R9", 15, 32'd9);
    check("R10", 13, 32'd3);
    check("R11", 0, 32'd0);
    check("R2", 2, 32'd3);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

endmodule